// File: doc/BRIEF.md
# Serial Peripheral EEPROM Command Engine

This block is the command side of a serial-bus EEPROM. It acts as a bus slave in clock modes 0 and 3. It oversamples the chip-select, serial clock and serial data pins with the system clock and decodes 8-bit opcodes. It then runs array reads, page writes, status reads and status writes against an internal 2048-byte array. A programming operation is committed only at a clean frame end. A self-timed busy period follows, modelled as a fixed count of system clocks. During that period the page buffer is copied into the array.

Write protection lives in a neighbouring block. This engine exposes the write-enable latch and the busy bit to it. It presents the page that a pending array write targets and asks for a per-page permit. It hands a committed status byte over on a one-cycle strobe, subject to a status permit. The neighbour supplies the five configuration bits that appear in the upper part of the status byte.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset, WEL, the flag and WIP are 0 and SO is not driven. No frame starts until a high-to-low transition of CS is seen after reset, so clocks sent while CS was already low at reset have no effect.
- R2: Bits are taken MSB first on SCK rising edges, and SO changes after SCK falling edges. Reads work with SCK idling low (mode 0) and idling high (mode 3).
- R3: `so_oe` is 0 whenever `cs_n` is high, and 1 only while read or status data is being shifted out.
- R4: The opcodes 0x06 (set WEL), 0x04 (clear WEL and clear flag) and 0x00 (set flag) act only when CS rises right after their 8 bits. Any extra SCK rising edge in the same frame voids them.
- R5: Opcode 0x05 shifts out the status byte and repeats it while clocks continue. Its layout is bit7 = `cfg_bits[4]`, bit6 = flag, bits5..2 = `cfg_bits[3:0]`, bit1 = WEL, bit0 = WIP.
- R6: Opcode 0x03 takes a 16-bit address and uses only its low 11 bits. It then streams bytes, incrementing after each byte and wrapping from 0x7FF to 0x000 until CS rises.
- R7: Opcode 0x02 takes a 16-bit address (low 11 bits used) and then data bytes. The address increments within its 32-byte page and wraps to the start of that page. Without WEL = 1, nothing is written.
- R8: A write or status write commits only if CS rises on a byte boundary after at least one data byte while WEL = 1. Otherwise the frame is discarded and WEL keeps its value.
- R9: Opcode 0x01 followed by one byte, when committed with `sr_permit` = 1, emits a one-cycle `sr_wr_stb` carrying that byte on `sr_wr_data`. With `sr_permit` = 0 nothing happens.
- R10: An array write to a page for which `page_permit` is 0 at commit does not start and leaves the array unchanged.
- R11: A commit clears WEL and raises WIP on the next cycle. WIP stays 1 for WR_CYCLES cycles, and status reads remain possible meanwhile.
- R12: While WIP = 1 every opcode other than 0x05 is ignored.
- R13: An undefined opcode is ignored: SO stays undriven for the rest of the frame and WEL is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for `so` (tri-state control) |
| cfg_bits | input | 5 | Protection configuration bits shown in the status byte |
| page_permit | input | 1 | Permit for an array write to page `page_sel` |
| sr_permit | input | 1 | Permit for a status write |
| page_sel | output | 6 | Page targeted by the current write pointer |
| sr_wr_stb | output | 1 | One-cycle strobe of a committed status write |
| sr_wr_data | output | 8 | Status byte being written |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write in progress |

## Verification
Every pin edge passes two synchronizer flops and one registered edge decision. A new SO bit is therefore stable about three system clocks after a SCK fall. The bench holds each SCK phase for six clocks and has its monitor capture SO at the following rise. A commit is decided about three clocks after CS rises and WIP follows one clock later, so WEL, WIP and the status strobe are checked ten clocks after CS is released. Array contents are read back only after waiting longer than WR_CYCLES plus the drain of the page buffer.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    typedef enum logic [2:0] {
        PH_OP     = 3'd0,
        PH_ADDR   = 3'd1,
        PH_WDATA  = 3'd2,
        PH_SRDATA = 3'd3,
        PH_RDATA  = 3'd4,
        PH_RSTAT  = 3'd5,
        PH_CMDEND = 3'd6,
        PH_IGNORE = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_WREN = 2'd1,
        CMD_WRDI = 2'd2,
        CMD_SFLB = 2'd3
    } cmd_e;

    localparam logic [7:0] OP_SET_WEL  = 8'h06;
    localparam logic [7:0] OP_SET_FLAG = 8'h00;
    localparam logic [7:0] OP_CLR_WEL  = 8'h04;
    localparam logic [7:0] OP_RD_STAT  = 8'h05;
    localparam logic [7:0] OP_WR_STAT  = 8'h01;
    localparam logic [7:0] OP_RD_ARRAY = 8'h03;
    localparam logic [7:0] OP_WR_ARRAY = 8'h02;

endpackage

// File: rtl/spi_ee_pin_sync.sv
module spi_ee_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
        end
        assign lvl_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
    parameter int AW        = 11,
    parameter int PW        = 5,
    parameter int WR_CYCLES = 1500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_clr_i,
    input  logic          buf_we_i,
    input  logic [PW-1:0] buf_idx_i,
    input  logic [7:0]    buf_data_i,
    input  logic          commit_arr_i,
    input  logic          commit_sr_i,
    input  logic [AW-PW-1:0] page_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    output logic          wip_o
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PW;
    localparam int BUSY  = (WR_CYCLES < PAGE) ? PAGE : WR_CYCLES;
    localparam int CW    = $clog2(BUSY + 1);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [PW:0]      widx;
        logic             arr;
        logic [AW-PW-1:0] page;
    } busy_t;

    busy_t busy_d, busy_q;

    logic [7:0]    mem [DEPTH];
    logic [7:0]    pbuf [PAGE];
    logic [PAGE-1:0] mask_q;

    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    always_comb begin
        busy_d    = busy_q;
        mem_we    = 1'b0;
        mem_addr  = {busy_q.page, busy_q.widx[PW-1:0]};
        mem_wdata = pbuf[busy_q.widx[PW-1:0]];
        if (commit_arr_i || commit_sr_i) begin
            busy_d.cnt  = CW'(BUSY);
            busy_d.widx = '0;
            busy_d.arr  = commit_arr_i;
            busy_d.page = page_i;
        end else if (busy_q.cnt != '0) begin
            busy_d.cnt = busy_q.cnt - 1'b1;
            if (busy_q.arr && !busy_q.widx[PW]) begin
                busy_d.widx = busy_q.widx + 1'b1;
                mem_we      = mask_q[busy_q.widx[PW-1:0]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= '0;
        else if (buf_clr_i) mask_q <= '0;
        else if (buf_we_i)  mask_q[buf_idx_i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (buf_we_i) pbuf[buf_idx_i] <= buf_data_i;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    assign rd_data_o = mem[rd_addr_i];
    assign wip_o     = (busy_q.cnt != '0);
endmodule

// File: rtl/spi_ee_seq.sv
module spi_ee_seq
    import spi_ee_pkg::*;
#(
    parameter int AW = 11,
    parameter int PW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s_i,
    input  logic             sck_s_i,
    input  logic             si_s_i,
    input  logic             wip_i,
    input  logic [7:0]       rd_data_i,
    input  logic [4:0]       cfg_i,
    input  logic             page_ok_i,
    input  logic             sr_ok_i,
    output logic             so_o,
    output logic             so_en_o,
    output logic             frame_o,
    output logic             wel_o,
    output logic             buf_clr_o,
    output logic             buf_we_o,
    output logic [PW-1:0]    buf_idx_o,
    output logic [7:0]       buf_data_o,
    output logic             commit_arr_o,
    output logic             commit_sr_o,
    output logic [7:0]       sr_data_o,
    output logic [AW-PW-1:0] page_o,
    output logic [AW-1:0]    rd_addr_o
);
    typedef struct packed {
        logic        cs_prev;
        logic        sck_prev;
        logic        frame;
        phase_e      ph;
        logic [2:0]  bi;
        logic [7:0]  isr;
        logic [15:0] addr;
        logic        second;
        logic        is_wr;
        cmd_e        cmd;
        logic        got;
        logic [7:0]  osr;
        logic        so;
        logic        soe;
        logic        wel;
        logic        flag;
        logic [7:0]  srb;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          cs_rise, cs_fall, sck_rise, sck_fall;
    logic [7:0]    byte_in, status, load;
    logic [15:0]   a16;
    logic [AW-1:0] ptr, ptr_pg;
    logic [PW-1:0] low_next;

    assign cs_rise  =  cs_s_i  & ~seq_q.cs_prev;
    assign cs_fall  = ~cs_s_i  &  seq_q.cs_prev;
    assign sck_rise =  sck_s_i & ~seq_q.sck_prev;
    assign sck_fall = ~sck_s_i &  seq_q.sck_prev;

    always_comb begin
        seq_d          = seq_q;
        seq_d.cs_prev  = cs_s_i;
        seq_d.sck_prev = sck_s_i;
        byte_in  = {seq_q.isr[6:0], si_s_i};
        a16      = {seq_q.addr[14:0], si_s_i};
        status   = {cfg_i[4], seq_q.flag, cfg_i[3:0], seq_q.wel, wip_i};
        ptr      = seq_q.addr[AW-1:0];
        low_next = ptr[PW-1:0] + 1'b1;
        ptr_pg   = {ptr[AW-1:PW], low_next};
        load     = (seq_q.ph == PH_RDATA) ? rd_data_i : status;
        buf_clr_o    = 1'b0;
        buf_we_o     = 1'b0;
        commit_arr_o = 1'b0;
        commit_sr_o  = 1'b0;

        if (cs_fall) begin
            seq_d.frame  = 1'b1;
            seq_d.ph     = PH_OP;
            seq_d.bi     = '0;
            seq_d.got    = 1'b0;
            seq_d.second = 1'b0;
            seq_d.cmd    = CMD_NONE;
            seq_d.soe    = 1'b0;
        end else if (cs_rise) begin
            if (seq_q.frame && seq_q.bi == 3'd0) begin
                case (seq_q.ph)
                    PH_CMDEND: begin
                        case (seq_q.cmd)
                            CMD_WREN: seq_d.wel = 1'b1;
                            CMD_WRDI: begin
                                seq_d.wel  = 1'b0;
                                seq_d.flag = 1'b0;
                            end
                            CMD_SFLB: seq_d.flag = 1'b1;
                            default: ;
                        endcase
                    end
                    PH_WDATA: begin
                        if (seq_q.got && seq_q.wel && page_ok_i) begin
                            commit_arr_o = 1'b1;
                            seq_d.wel    = 1'b0;
                        end
                    end
                    PH_SRDATA: begin
                        if (seq_q.got && seq_q.wel && sr_ok_i) begin
                            commit_sr_o = 1'b1;
                            seq_d.wel   = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            seq_d.frame = 1'b0;
            seq_d.soe   = 1'b0;
            seq_d.ph    = PH_OP;
        end else if (seq_q.frame) begin
            if (sck_rise) begin
                seq_d.isr = byte_in;
                seq_d.bi  = seq_q.bi + 1'b1;
                if (seq_q.ph == PH_ADDR) seq_d.addr = a16;
                if (seq_q.ph == PH_CMDEND) begin
                    seq_d.ph = PH_IGNORE;
                end else if (seq_q.bi == 3'd7) begin
                    case (seq_q.ph)
                        PH_OP: begin
                            if (wip_i && byte_in != OP_RD_STAT) begin
                                seq_d.ph = PH_IGNORE;
                            end else begin
                                case (byte_in)
                                    OP_SET_WEL: begin
                                        seq_d.ph  = PH_CMDEND;
                                        seq_d.cmd = CMD_WREN;
                                    end
                                    OP_CLR_WEL: begin
                                        seq_d.ph  = PH_CMDEND;
                                        seq_d.cmd = CMD_WRDI;
                                    end
                                    OP_SET_FLAG: begin
                                        seq_d.ph  = PH_CMDEND;
                                        seq_d.cmd = CMD_SFLB;
                                    end
                                    OP_RD_STAT:  seq_d.ph = PH_RSTAT;
                                    OP_WR_STAT:  seq_d.ph = PH_SRDATA;
                                    OP_RD_ARRAY: begin
                                        seq_d.ph    = PH_ADDR;
                                        seq_d.is_wr = 1'b0;
                                    end
                                    OP_WR_ARRAY: begin
                                        seq_d.ph    = PH_ADDR;
                                        seq_d.is_wr = 1'b1;
                                        buf_clr_o   = 1'b1;
                                    end
                                    default: seq_d.ph = PH_IGNORE;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            if (seq_q.second) begin
                                seq_d.addr = 16'(a16[AW-1:0]);
                                seq_d.ph   = seq_q.is_wr ? PH_WDATA : PH_RDATA;
                            end else begin
                                seq_d.second = 1'b1;
                            end
                        end
                        PH_WDATA: begin
                            buf_we_o   = 1'b1;
                            seq_d.got  = 1'b1;
                            seq_d.addr = 16'(ptr_pg);
                        end
                        PH_SRDATA: begin
                            seq_d.srb = byte_in;
                            seq_d.got = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end else if (sck_fall) begin
                if (seq_q.ph == PH_RDATA || seq_q.ph == PH_RSTAT) begin
                    seq_d.soe = 1'b1;
                    if (seq_q.bi == 3'd0) begin
                        seq_d.so  = load[7];
                        seq_d.osr = {load[6:0], 1'b0};
                        if (seq_q.ph == PH_RDATA) seq_d.addr = 16'(ptr + 1'b1);
                    end else begin
                        seq_d.so  = seq_q.osr[7];
                        seq_d.osr = {seq_q.osr[6:0], 1'b0};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign so_o       = seq_q.so;
    assign so_en_o    = seq_q.soe;
    assign frame_o    = seq_q.frame;
    assign wel_o      = seq_q.wel;
    assign buf_idx_o  = ptr[PW-1:0];
    assign buf_data_o = byte_in;
    assign sr_data_o  = seq_q.srb;
    assign page_o     = ptr[AW-1:PW];
    assign rd_addr_o  = ptr;
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int WR_CYCLES   = 1500,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     sck,
    input  logic                     si,
    output logic                     so,
    output logic                     so_oe,
    input  logic [4:0]               cfg_bits,
    input  logic                     page_permit,
    input  logic                     sr_permit,
    output logic [ADDR_W-PAGE_W-1:0] page_sel,
    output logic                     sr_wr_stb,
    output logic [7:0]               sr_wr_data,
    output logic                     wel,
    output logic                     wip
);
    logic [2:0]        pins_s;
    logic              so_en, frame;
    logic              buf_clr, buf_we, commit_arr, commit_sr;
    logic [PAGE_W-1:0] buf_idx;
    logic [7:0]        buf_data, rd_data;
    logic [ADDR_W-1:0] rd_addr;

    spi_ee_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({si, sck, cs_n}),
        .lvl_o (pins_s)
    );

    spi_ee_seq #(.AW(ADDR_W), .PW(PAGE_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_s_i       (pins_s[0]),
        .sck_s_i      (pins_s[1]),
        .si_s_i       (pins_s[2]),
        .wip_i        (wip),
        .rd_data_i    (rd_data),
        .cfg_i        (cfg_bits),
        .page_ok_i    (page_permit),
        .sr_ok_i      (sr_permit),
        .so_o         (so),
        .so_en_o      (so_en),
        .frame_o      (frame),
        .wel_o        (wel),
        .buf_clr_o    (buf_clr),
        .buf_we_o     (buf_we),
        .buf_idx_o    (buf_idx),
        .buf_data_o   (buf_data),
        .commit_arr_o (commit_arr),
        .commit_sr_o  (commit_sr),
        .sr_data_o    (sr_wr_data),
        .page_o       (page_sel),
        .rd_addr_o    (rd_addr)
    );

    spi_ee_store #(.AW(ADDR_W), .PW(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .buf_clr_i    (buf_clr),
        .buf_we_i     (buf_we),
        .buf_idx_i    (buf_idx),
        .buf_data_i   (buf_data),
        .commit_arr_i (commit_arr),
        .commit_sr_i  (commit_sr),
        .page_i       (page_sel),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .wip_o        (wip)
    );

    assign so_oe     = so_en & frame & ~cs_n;
    assign sr_wr_stb = commit_sr;
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic so_oe,
    input logic frame,
    input logic wel,
    input logic wip,
    input logic buf_clr,
    input logic commit_arr,
    input logic commit_sr
);
    assert_hiz_when_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_oe);

    assert_drive_only_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> frame);

    assert_commit_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_arr || commit_sr) |-> wel);

    assert_busy_after_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_arr || commit_sr) |=> (wip && !wel));

    assert_busy_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(commit_arr || commit_sr));

    assert_quiet_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> (!buf_clr && !commit_arr && !commit_sr));
endmodule

bind spi_eeprom_ctrl spi_ee_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .so_oe      (so_oe),
    .frame      (frame),
    .wel        (wel),
    .wip        (wip),
    .buf_clr    (buf_clr),
    .commit_arr (commit_arr),
    .commit_sr  (commit_sr)
);

// File: tb/test_spi_eeprom_ctrl.sv
module test_spi_eeprom_ctrl;
    localparam int H    = 6;
    localparam int WAIT = 1600;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, si = 1'b0;
    logic so, so_oe, page_permit, sr_permit, sr_wr_stb, wel, wip;
    logic [4:0] cfg_bits = 5'b10110;
    logic [5:0] page_sel;
    logic [7:0] sr_wr_data;
    logic lock = 1'b0;
    logic sr_ok = 1'b1;

    int total = 0, bad = 0;
    int sr_cnt = 0;
    logic [7:0] sr_last = '0;

    typedef struct { logic [7:0] v; string req; } exp_t;
    exp_t expq[$];
    logic mon_en = 1'b0;
    logic [7:0] mon_sh = '0;
    int mon_n = 0;

    always #4 clk = ~clk;

    assign page_permit = !(lock && page_sel >= 6'd48);
    assign sr_permit   = sr_ok;

    spi_eeprom_ctrl i_spi_eeprom_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .cfg_bits(cfg_bits),
        .page_permit(page_permit), .sr_permit(sr_permit),
        .page_sel(page_sel), .sr_wr_stb(sr_wr_stb), .sr_wr_data(sr_wr_data),
        .wel(wel), .wip(wip)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) if (sr_wr_stb) begin
        sr_cnt  = sr_cnt + 1;
        sr_last = sr_wr_data;
    end

    always @(posedge sck) if (mon_en) begin
        exp_t e;
        mon_sh = {mon_sh[6:0], so & so_oe};
        mon_n  = mon_n + 1;
        if (mon_n == 8) begin
            mon_n = 0;
            if (expq.size() == 0) chk(1'b0, "queue", 16'(mon_sh), 16'hxxxx);
            else begin
                e = expq.pop_front();
                chk(mon_sh === e.v, e.req, 16'(mon_sh), 16'(e.v));
            end
        end
    end

    function automatic logic [7:0] stat(input bit flag, input bit w, input bit busy);
        return {cfg_bits[4], flag, cfg_bits[3:0], w, busy};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_lo(input bit mode3);
        sck = mode3; tick(4); cs_n = 1'b0; tick(6);
    endtask

    task automatic cs_hi(input bit mode3);
        if (!mode3) begin sck = 1'b0; tick(H); end
        cs_n = 1'b1; tick(10);
    endtask

    task automatic bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sck = 1'b0; si = b[i]; tick(H);
            sck = 1'b1; tick(H);
        end
    endtask

    task automatic tx(input logic [7:0] b);
        bits(b, 8);
    endtask

    task automatic rx(input logic [7:0] e, input string req);
        exp_t it;
        it.v = e; it.req = req;
        expq.push_back(it);
        mon_en = 1'b1;
        tx(8'h00);
        mon_en = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] op);
        cs_lo(1'b0); tx(op); cs_hi(1'b0);
    endtask

    task automatic rdsr(input logic [7:0] e, input string req);
        cs_lo(1'b0); tx(8'h05); rx(e, req); cs_hi(1'b0);
    endtask

    task automatic wr_start(input logic [15:0] a);
        cs_lo(1'b0); tx(8'h02); tx(a[15:8]); tx(a[7:0]);
    endtask

    task automatic rd_start(input logic [15:0] a, input bit mode3);
        cs_lo(mode3); tx(8'h03); tx(a[15:8]); tx(a[7:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(5); rst_n = 1'b1; tick(3);
        // R1: reset state at the ports
        chk(wel == 1'b0 && wip == 1'b0 && so_oe == 1'b0, "R1", {13'd0, wel, wip, so_oe}, 16'h0);
        // R1: opcode clocked while CS was low since reset is not a frame
        tx(8'h06); cs_hi(1'b0);
        chk(wel == 1'b0, "R1", 16'(wel), 16'h0);
        rdsr(stat(0, 0, 0), "R1");
        // R3: deselected output is undriven
        chk(so_oe == 1'b0, "R3", 16'(so_oe), 16'h0);

        // R5: status repeats; R2: mode 3 read of status
        cs_lo(1'b0); tx(8'h05); rx(stat(0, 0, 0), "R5"); rx(stat(0, 0, 0), "R5"); cs_hi(1'b0);
        cs_lo(1'b1); tx(8'h05); rx(stat(0, 0, 0), "R2"); cs_hi(1'b1);

        // R4: enable, disable, voided enable, flag set/clear
        cmd(8'h06);
        chk(wel == 1'b1, "R4", 16'(wel), 16'h1);
        rdsr(stat(0, 1, 0), "R4");
        cmd(8'h04);
        chk(wel == 1'b0, "R4", 16'(wel), 16'h0);
        cs_lo(1'b0); tx(8'h06); bits(8'h00, 1); cs_hi(1'b0);
        chk(wel == 1'b0, "R4", 16'(wel), 16'h0);
        cmd(8'h00);
        rdsr(stat(1, 0, 0), "R4");
        cmd(8'h04);
        rdsr(stat(0, 0, 0), "R4");

        // R6/R7: page 0 write with upper address bits set
        cmd(8'h06);
        wr_start(16'hF800); tx(8'h11); tx(8'h22); cs_hi(1'b0);
        chk(wip == 1'b1, "R11", 16'(wip), 16'h1);
        chk(wel == 1'b0, "R11", 16'(wel), 16'h0);
        rdsr(stat(0, 0, 1), "R11");
        // R12: commands during busy are ignored
        cmd(8'h06);
        rd_start(16'h0000, 1'b0); tx(8'h00);
        chk(so_oe == 1'b0, "R12", 16'(so_oe), 16'h0);
        cs_hi(1'b0);
        tick(WAIT);
        chk(wip == 1'b0, "R11", 16'(wip), 16'h0);
        chk(wel == 1'b0, "R12", 16'(wel), 16'h0);

        // R7: top page with in-page wrap
        cmd(8'h06);
        wr_start(16'h07FE); tx(8'hAA); tx(8'hBB); tx(8'hCC); cs_hi(1'b0);
        tick(WAIT);
        // R6: sequential read rolls over the array end
        rd_start(16'h07FE, 1'b0);
        rx(8'hAA, "R6"); rx(8'hBB, "R6"); rx(8'h11, "R6"); rx(8'h22, "R6");
        cs_hi(1'b0);
        rd_start(16'h07E0, 1'b1); rx(8'hCC, "R7"); cs_hi(1'b1);

        // R7: no write without WEL
        wr_start(16'h0001); tx(8'h55); cs_hi(1'b0);
        chk(wip == 1'b0, "R7", 16'(wip), 16'h0);

        // R8: misaligned end and empty write are discarded
        cmd(8'h06);
        wr_start(16'h0000); tx(8'h99); bits(8'hFF, 3); cs_hi(1'b0);
        chk(wip == 1'b0, "R8", 16'(wip), 16'h0);
        chk(wel == 1'b1, "R8", 16'(wel), 16'h1);
        wr_start(16'h0000); cs_hi(1'b0);
        chk(wip == 1'b0, "R8", 16'(wip), 16'h0);
        rd_start(16'h0000, 1'b0); rx(8'h11, "R8"); rx(8'h22, "R7"); cs_hi(1'b0);

        // R9: status write committed and refused
        cs_lo(1'b0); tx(8'h01); tx(8'hA5); cs_hi(1'b0);
        chk(sr_cnt == 1 && sr_last == 8'hA5, "R9", {8'(sr_cnt), sr_last}, 16'h01A5);
        chk(wip == 1'b1, "R9", 16'(wip), 16'h1);
        tick(WAIT);
        sr_ok = 1'b0;
        cmd(8'h06);
        cs_lo(1'b0); tx(8'h01); tx(8'h3C); cs_hi(1'b0);
        chk(sr_cnt == 1 && wip == 1'b0, "R9", {8'(sr_cnt), 7'd0, wip}, 16'h0100);
        sr_ok = 1'b1;

        // R10: refused page stays unchanged
        lock = 1'b1;
        wr_start(16'h07FE); tx(8'h77); cs_hi(1'b0);
        chk(wip == 1'b0, "R10", 16'(wip), 16'h0);
        lock = 1'b0;
        rd_start(16'h07FE, 1'b0); rx(8'hAA, "R10"); cs_hi(1'b0);

        // R13: undefined opcode
        cs_lo(1'b0); tx(8'h9F); tx(8'h00);
        chk(so_oe == 1'b0, "R13", 16'(so_oe), 16'h0);
        cs_hi(1'b0);
        chk(wel == 1'b1, "R13", 16'(wel), 16'h1);

        chk(expq.size() == 0, "R2", 16'(expq.size()), 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule